// File: doc/BRIEF.md
# SDRAM Command Legality Tracker

This block watches the command pins between a memory controller and a four-bank single-data-rate SDRAM. In every clock cycle it turns chip select, row strobe, column strobe, write enable and clock enable into one command code. It keeps a record of which banks hold an open row and flags any command that breaks the bank-state or spacing rules. Each flag comes with a code that gives the reason.

The decoded command and the error outputs are combinational from the current pins and the stored state. The per-bank open flags are registered and change at the clock edge that ends the command's cycle. An illegal command is still reported on the command output, but it changes neither the bank state nor any counter. Burst length is set at elaboration through `BURST_LEN` (1, 2, 4 or 8).

Top module: `sdram_cmd_checker`

## Requirements
- R1: While `rst_n` is low, `err_o` is 0. On the first cycle after reset all banks read closed (`bank_open_o` = 0) and no lockout after a mode-register set is pending.
- R2: With `cke` high, `cmd_o` is 8 when `cs_n` is high. Otherwise `cmd_o` is {0, ras_n, cas_n, we_n}: 0 mode set, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 6 burst stop, 7 NOP.
- R3: A legal activate sets bit `ba` of `bank_open_o` (bit 0 is bank A, bit 3 is bank D). An activate to an open bank gives error code 5 and changes nothing.
- R4: A precharge with address bit 10 low closes bank `ba`. With bit 10 high it closes all four banks and `ba` is ignored. Precharge is never an error.
- R5: A read or write to a closed bank gives error code 4 and leaves every bank state unchanged.
- R6: A mode-register set while any bank is open gives error code 2.
- R7: After a legal mode-register set, any command other than NOP or deselect in the next 2 cycles gives error code 1 and is ignored.
- R8: A refresh or self-refresh entry while any bank is open gives error code 3.
- R9: A legal read or write with address bit 10 high starts an auto-precharge burst. For the next `BURST_LEN`-1 cycles any read or write gives error code 6 and is ignored. The bank reads closed `BURST_LEN` cycles after the command, and from that cycle a read or write to any open bank is accepted.
- R10: When more than one error applies, code 1 wins over code 6, and code 6 wins over code 4.
- R11: With `cke` low, the refresh pin pattern decodes as self-refresh entry (`cmd_o` = 9). Every other pattern decodes as NOP (7), has no effect and is never an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | ADDR_W | Address pins; bit 10 selects auto/all-bank |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 1 | Illegal command this cycle |
| err_code_o | output | 3 | Error reason (0 when none) |
| bank_open_o | output | 4 | Per-bank open flag |

## Verification
The bench builds the block with `BURST_LEN` = 4. This gives a three-cycle auto-precharge window, so blocked reads and writes can be tried in the middle of the window and at its end, with the bank closing one cycle later. The lockout after a mode-register set keeps its fixed two cycles. Random command streams then mix the lockout with the burst window and with open and closed banks, which exercises the priority order.

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker #(
  parameter int BURST_LEN = 4,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int MRS_GAP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        cmd_o,
  output logic              err_o,
  output logic [2:0]        err_code_o,
  output logic [3:0]        bank_open_o
);
  localparam int APW = $clog2(BURST_LEN + 1);
  localparam int LKW = $clog2(MRS_GAP + 1);

  localparam logic [3:0] C_MRS = 4'd0, C_REF = 4'd1, C_PRE = 4'd2, C_ACT = 4'd3,
                         C_WR = 4'd4, C_RD = 4'd5, C_NOP = 4'd7, C_DES = 4'd8,
                         C_SREF = 4'd9;

  logic [3:0]     open_q, open_d;
  logic [APW-1:0] ap_left_q;
  logic [1:0]     ap_bank_q;
  logic [LKW-1:0] lock_q;

  wire ref_pat = !cs_n && !ras_n && !cas_n && we_n;

  always_comb begin
    if (!cke)      cmd_o = ref_pat ? C_SREF : C_NOP;
    else if (cs_n) cmd_o = C_DES;
    else           cmd_o = {1'b0, ras_n, cas_n, we_n};
  end

  wire is_rw   = (cmd_o == C_WR) || (cmd_o == C_RD);
  wire quiet   = (cmd_o == C_NOP) || (cmd_o == C_DES);
  wire any_opn = |open_q;
  wire ap_bit  = addr[AP_BIT];

  always_comb begin
    err_code_o = 3'd0;
    if (lock_q != '0 && !quiet)                        err_code_o = 3'd1;
    else if (is_rw && ap_left_q != '0)                 err_code_o = 3'd6;
    else if (is_rw && !open_q[ba])                     err_code_o = 3'd4;
    else if (cmd_o == C_ACT && open_q[ba])             err_code_o = 3'd5;
    else if (cmd_o == C_MRS && any_opn)                err_code_o = 3'd2;
    else if ((cmd_o == C_REF || cmd_o == C_SREF) && any_opn) err_code_o = 3'd3;
    if (!rst_n) err_code_o = 3'd0;
  end

  assign err_o       = err_code_o != 3'd0;
  assign bank_open_o = open_q;

  wire legal = rst_n && !err_o;

  always_comb begin
    open_d = open_q;
    if (ap_left_q == APW'(1)) open_d[ap_bank_q] = 1'b0;
    if (legal) begin
      if (cmd_o == C_ACT) open_d[ba] = 1'b1;
      if (cmd_o == C_PRE) begin
        if (ap_bit) open_d = 4'b0000;
        else        open_d[ba] = 1'b0;
      end
      if (is_rw && ap_bit && BURST_LEN == 1) open_d[ba] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= '0;
      ap_left_q <= '0;
      ap_bank_q <= '0;
      lock_q    <= '0;
    end else begin
      open_q <= open_d;
      if (legal && cmd_o == C_MRS)  lock_q <= LKW'(MRS_GAP);
      else if (lock_q != '0)        lock_q <= lock_q - 1'b1;
      if (ap_left_q != '0)          ap_left_q <= ap_left_q - 1'b1;
      if (legal && is_rw && ap_bit && BURST_LEN > 1) begin
        ap_left_q <= APW'(BURST_LEN - 1);
        ap_bank_q <= ba;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ba,
  input logic       a10,
  input logic [3:0] cmd_o,
  input logic       err_o,
  input logic [2:0] err_code_o,
  input logic [3:0] bank_open_o
);
  assert_quiet_reset_R1: assert property (@(posedge clk) !rst_n |-> !err_o);

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd3 && !err_o) |=> bank_open_o[$past(ba)]);

  assert_pre_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd2 && a10 && !err_o) |=> bank_open_o == 4'd0);

  assert_rw_closed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code_o == 3'd4) |=> $stable(bank_open_o));

  assert_mrs_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd0 && bank_open_o != 4'd0) |-> err_o);

  assert_mrs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd0 && !err_o) |=> (cmd_o == 4'd7 || cmd_o == 4'd8 || err_code_o == 3'd1));
endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva chk_i (
  .clk(clk), .rst_n(rst_n), .ba(ba), .a10(addr[AP_BIT]), .cmd_o(cmd_o),
  .err_o(err_o), .err_code_o(err_code_o), .bank_open_o(bank_open_o)
);

// File: tb/sdram_cmd_checker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_checker_tb_top;
  localparam int BL = 4;
  logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [11:0] addr = 0;
  logic [3:0] cmd_o, bank_open_o;
  logic err_o;
  logic [2:0] err_code_o;
  int tests = 0, fails = 0;
  bit done = 0;

  bit m_open[4];
  int m_ap = 0, m_apb = 0, m_lock = 0;

  always #4 clk = ~clk;

  sdram_cmd_checker #(.BURST_LEN(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .err_o(err_o),
    .err_code_o(err_code_o), .bank_open_o(bank_open_o));

  function automatic logic [3:0] mopen();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = m_open[i];
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [3:0] ec, input logic [2:0] ee,
                       input logic [3:0] eo);
    tests++;
    if (cmd_o !== ec || err_code_o !== ee || err_o !== (ee != 0) || bank_open_o !== eo) begin
      fails++;
      $display("FAIL %s: cmd=%0d code=%0d err=%0b open=%b expected cmd=%0d code=%0d open=%b",
               tag, cmd_o, err_code_o, err_o, bank_open_o, ec, ee, eo);
    end
  endtask

  task automatic cyc(input string tag, input bit k, input bit cs, input bit r,
                     input bit c, input bit w, input int b, input bit a10);
    int code, e;
    bool_blk: begin end
    @(posedge clk); #1;
    cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = 2'(b);
    addr = 12'($urandom) & ~12'h400; addr[10] = a10;
    @(negedge clk);
    if (!k) code = (!cs && !r && !c && w) ? 9 : 7;
    else if (cs) code = 8;
    else code = {r, c, w};
    e = 0;
    begin
      bit rw = (code == 4 || code == 5);
      bit anyo = m_open[0] | m_open[1] | m_open[2] | m_open[3];
      if (m_lock > 0 && code != 7 && code != 8) e = 1;
      else if (rw && m_ap > 0) e = 6;
      else if (rw && !m_open[b]) e = 4;
      else if (code == 3 && m_open[b]) e = 5;
      else if (code == 0 && anyo) e = 2;
      else if ((code == 1 || code == 9) && anyo) e = 3;
      check(tag, 4'(code), 3'(e), mopen());
      if (m_ap == 1) m_open[m_apb] = 0;
      if (m_ap > 0) m_ap--;
      if (e == 0 && code == 0) m_lock = 2;
      else if (m_lock > 0) m_lock--;
      if (e == 0) begin
        if (code == 3) m_open[b] = 1;
        if (code == 2) begin
          if (a10) for (int i = 0; i < 4; i++) m_open[i] = 0;
          else m_open[b] = 0;
        end
        if (rw && a10) begin
          if (BL == 1) m_open[b] = 0;
          else begin m_ap = BL - 1; m_apb = b; end
        end
      end
    end
  endtask

  task automatic op(input string tag, input int cmd, input int b, input bit a10);
    cyc(tag, 1, 0, cmd[2], cmd[1], cmd[0], b, a10);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; cke = 1; cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0;
    repeat (2) begin
      @(negedge clk);
      tests++;
      if (err_o !== 1'b0) begin
        fails++; $display("FAIL R1: err=%0b during reset expected 0", err_o);
      end
    end
    @(posedge clk); #1;
    rst_n = 1; cs_n = 0; ras_n = 1; cas_n = 1; we_n = 1;
    for (int i = 0; i < 4; i++) m_open[i] = 0;
    m_ap = 0; m_lock = 0;
    @(negedge clk);
    check("R1 after reset", 4'd7, 3'd0, 4'd0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not end, expected finish");
    finish_run();
  end

  initial begin
    do_reset();
    op("R2 nop", 7, 0, 0);
    cyc("R2 deselect", 1, 1, 0, 0, 0, 0, 0);
    op("R2 burst stop", 6, 0, 0);
    op("R3 act C", 3, 2, 0);
    op("R3 act C again", 3, 2, 0);
    op("R5 read closed A", 5, 0, 0);
    op("R5 write open C", 4, 2, 0);
    op("R6 mrs with open", 0, 0, 0);
    op("R8 refresh with open", 1, 0, 0);
    cyc("R11 self refresh with open", 0, 0, 0, 0, 1, 0, 0);
    cyc("R11 cke low act", 0, 0, 0, 1, 1, 1, 0);
    op("R3 act B", 3, 1, 0);
    op("R4 pre C", 2, 2, 0);
    op("R3 act A", 3, 0, 0);
    op("R3 act D", 3, 3, 0);
    op("R4 pre all", 2, 0, 1);
    op("R4 check closed", 7, 0, 0);
    op("R7 mrs legal", 0, 0, 0);
    op("R7 act locked", 3, 1, 0);
    op("R7 ref locked", 1, 0, 0);
    op("R7 act after gap", 3, 1, 0);
    op("R4 pre all", 2, 3, 1);
    op("R7 mrs", 0, 0, 0);
    op("R10 lock over closed read", 5, 0, 0);
    op("R7 nop", 7, 0, 0);
    op("R7 mrs before reset", 0, 0, 0);
    do_reset();
    op("R1 act right after reset", 3, 0, 0);
    op("R3 act B", 3, 1, 0);
    op("R9 read A auto", 5, 0, 1);
    op("R9 read B blocked", 5, 1, 0);
    op("R10 busy over closed", 4, 2, 0);
    op("R9 write B blocked end", 4, 1, 0);
    op("R9 read B after burst", 5, 1, 0);
    op("R9 A closed", 7, 0, 0);
    op("R9 write B auto", 4, 1, 1);
    op("R9 nop", 7, 0, 0);
    op("R9 nop", 7, 0, 0);
    op("R9 nop", 7, 0, 0);
    op("R9 B closed", 7, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 16;
      int b = $urandom % 4;
      bit a = $urandom % 2;
      if (r < 2) cyc("R11 mixed", 0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, b, a);
      else if (r < 4) cyc("R2 mixed", 1, $urandom % 2, 1, 1, 1, b, a);
      else if (r < 7) op("R3 mixed", 3, b, a);
      else if (r < 9) op("R4 mixed", 2, b, a);
      else if (r < 12) op("R9 mixed", 4 + ($urandom % 2), b, a);
      else if (r < 13) op("R6 mixed", 0, b, a);
      else if (r < 14) op("R8 mixed", 1, b, a);
      else op("R10 mixed", $urandom % 8, b, a);
    end
    finish_run();
  end
endmodule